// File: doc/BRIEF.md
# Power-Stage Control and Fault Register

This block is the byte-wide register file that sits between a processor bus and a group of power output stages. It has three high-side switches, a half-bridge group split into high-side and low-side FETs, an auxiliary supply output and a bus transmitter. A control register holds a global power-on bit, shutdown-disable bits for the thermal and supply-voltage interrupts, and two plain select bits. A drive register holds a static on bit and a PWM-select bit for each high-side switch. A status register latches overcurrent events.

An overcurrent event on a high-side switch or on the auxiliary output sets a sticky flag. The flag keeps that output off until software writes 1 to it. The stage enables are registered. Each is the global power-on bit ANDed with the absence of a latched fault, the absence of any automatic shutdown that is armed, and either the static on bit or the shared PWM input. The same control register also takes Stop and Sleep mode commands. Each command is accepted only when the rest of the written byte is clean, and it is reported as a one-cycle request.

Top module: `psc_regs`

## Requirements
- R1: After reset every register bit is 0, every stage enable and mode request is 0, and every readable address returns 0x00.
- R2: The control register is at address 0x00. Bit 7 is power-on, bit 4 disables low-side thermal shutdown, bit 3 disables high-side thermal shutdown, bit 2 disables voltage shutdown, and bits 1:0 are read/write select bits. Bits 6 and 5 always read 0.
- R3: The drive register is at address 0x02. Bits 2:0 are the static on bits of high-sides 3..1, bits 6:4 are their PWM-select bits, and bits 7 and 3 read 0.
- R4: The status register is at address 0x04. Bit 7 is the auxiliary overcurrent flag, bits 2:0 are the overcurrent flags of high-sides 3..1, and bits 6:3 read 0. A fault input sets its flag at the next clock edge, and the matching output is off from that edge on.
- R5: Writing 1 to a status flag clears it and re-enables its output on the same edge. Writing 0 leaves the flag unchanged.
- R6: When a fault input is high in the cycle of a write-1 clear of its flag, the flag stays set.
- R7: When power-on is 0, every stage enable is 0. All enables are registered and reflect a register write on the edge that captures it.
- R8: A high-side with its PWM-select bit at 1 follows the PWM input instead of its static on bit.
- R9: While the thermal interrupt is high and bit 3 is 0, the high-side switches and the half-bridge high-side permission are forced off. With bit 3 at 1 they are not affected.
- R10: While the thermal interrupt is high and bit 4 is 0, the half-bridge low-side permission is forced off. With bit 4 at 1 it is not affected.
- R11: While the voltage interrupt is high and bit 2 is 0, every stage enable is forced off. With bit 2 at 1 the interrupt has no effect.
- R12: A control write with bit 6 (Stop) or bit 5 (Sleep) set raises that request for exactly one cycle. This happens only if every other bit in positions 7..2 of the byte is 0, otherwise the command is dropped. The remaining bits of the byte are written normally in either case.
- R13: A CPU interrupt request in the cycle of a mode command cancels the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| hs_oc | input | 3 | High-side overcurrent events |
| aux_oc | input | 1 | Auxiliary output overcurrent event |
| pwm_in | input | 1 | Shared PWM drive input |
| temp_irq | input | 1 | High-temperature interrupt |
| volt_irq | input | 1 | Low/high-voltage interrupt |
| cpu_irq | input | 1 | CPU interrupt request |
| hs_en | output | 3 | High-side switch enables |
| aux_en | output | 1 | Auxiliary supply output enable |
| hb_hi_allow | output | 1 | Half-bridge high-side FET permission |
| hb_lo_allow | output | 1 | Half-bridge low-side FET permission |
| xmit_allow | output | 1 | Transmitter enable |
| stop_req | output | 1 | One-cycle Stop request |
| sleep_req | output | 1 | One-cycle Sleep request |
| sel_bits | output | 2 | Control select bits 1:0 |

## Verification
Two collisions can happen in one cycle: a fault event and a software clear of the same flag, and a mode command and a CPU interrupt. The bench raises `hs_oc` in the same cycle as a write of 1 to that flag's status bit. It expects the flag to read 1 and the output to stay off. It also writes a clean Stop byte while `cpu_irq` is high and expects no request on the following edge. A fault and a clear that fall in different cycles are run as a control, to show that the clear path works by itself.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DW         = 8;
  localparam int AW         = 8;
  localparam int CTRL_ADDR  = 0;
  localparam int DRV_ADDR   = 2;
  localparam int STAT_ADDR  = 4;
  localparam int PSON_BIT   = 7;
  localparam int STOP_BIT   = 6;
  localparam int SLEEP_BIT  = 5;
  localparam int LSTD_BIT   = 4;
  localparam int HSTD_BIT   = 3;
  localparam int VSD_BIT    = 2;
  localparam logic [DW-1:0] CMD_FIELD = 8'hFC;
  localparam logic [DW-1:0] WO_MASK   = (8'h1 << STOP_BIT) | (8'h1 << SLEEP_BIT);

  // True when every bit in 7..2 other than the command bit itself is 0
  function automatic logic cmd_clean(input logic [DW-1:0] d, input int keep);
    logic [DW-1:0] m;
    m = CMD_FIELD & ~(8'h1 << keep);
    return (d & m) == '0;
  endfunction

  // Next flag value: set wins over clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/psc_ctrl_reg.sv
module psc_ctrl_reg
  import psc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          cpu_irq,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] ctrl_nxt,
  output logic          stop_req,
  output logic          sleep_req
);
  logic stop_ok, sleep_ok;

  assign ctrl_nxt = wr_ctrl ? (wdata & ~WO_MASK) : ctrl_q;
  assign stop_ok  = wr_ctrl & wdata[STOP_BIT]  & cmd_clean(wdata, STOP_BIT)  & ~cpu_irq;
  assign sleep_ok = wr_ctrl & wdata[SLEEP_BIT] & cmd_clean(wdata, SLEEP_BIT) & ~cpu_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      stop_req  <= 1'b0;
      sleep_req <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      stop_req  <= stop_ok;
      sleep_req <= sleep_ok;
    end
  end

  assert_stop_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);
  assert_sleep_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !sleep_req);
  assert_dirty_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[STOP_BIT] && wdata[PSON_BIT]) |=> !stop_req);
  assert_irq_cancel_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> (!stop_req && !sleep_req));
  assert_wo_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[STOP_BIT] == 1'b0 && ctrl_q[SLEEP_BIT] == 1'b0);
endmodule

// File: rtl/psc_fault_flags.sv
module psc_fault_flags
  import psc_pkg::*;
#(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flag_q,
  output logic [NF-1:0] flag_nxt
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flag_nxt[i] = flag_next(flag_q[i], fault[i], clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_nxt[i];
    end

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault[i] |=> flag_q[i]);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !fault[i]) |=> !flag_q[i]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/psc_out_stage.sv
module psc_out_stage #(
  parameter int NUM_HS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pson,
  input  logic              hs_tdis,
  input  logic              ls_tdis,
  input  logic              v_tdis,
  input  logic              temp_irq,
  input  logic              volt_irq,
  input  logic [NUM_HS-1:0] hs_on,
  input  logic [NUM_HS-1:0] hs_pwm_sel,
  input  logic              pwm_in,
  input  logic [NUM_HS-1:0] hs_fault,
  input  logic              aux_fault,
  output logic [NUM_HS-1:0] hs_en,
  output logic              aux_en,
  output logic              hb_hi_allow,
  output logic              hb_lo_allow,
  output logic              xmit_allow
);
  logic base_ok, hi_kill, lo_kill;
  logic [NUM_HS-1:0] hs_drive, hs_nxt;

  assign base_ok = pson & ~(volt_irq & ~v_tdis);
  assign hi_kill = temp_irq & ~hs_tdis;
  assign lo_kill = temp_irq & ~ls_tdis;

  for (genvar i = 0; i < NUM_HS; i++) begin : g_hs
    assign hs_drive[i] = hs_pwm_sel[i] ? pwm_in : hs_on[i];
    assign hs_nxt[i]   = base_ok & ~hi_kill & ~hs_fault[i] & hs_drive[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en       <= '0;
      aux_en      <= 1'b0;
      hb_hi_allow <= 1'b0;
      hb_lo_allow <= 1'b0;
      xmit_allow  <= 1'b0;
    end else begin
      hs_en       <= hs_nxt;
      aux_en      <= base_ok & ~aux_fault;
      hb_hi_allow <= base_ok & ~hi_kill;
      hb_lo_allow <= base_ok & ~lo_kill;
      xmit_allow  <= base_ok;
    end
  end

  assert_pson_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pson |=> (hs_en == '0 && !aux_en && !hb_hi_allow && !hb_lo_allow && !xmit_allow));
  assert_volt_kill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_irq && !v_tdis) |=> (hs_en == '0 && !aux_en && !hb_hi_allow && !hb_lo_allow && !xmit_allow));
  assert_hi_therm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_irq && !hs_tdis) |=> (hs_en == '0 && !hb_hi_allow));
  assert_lo_therm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_irq && !ls_tdis) |=> !hb_lo_allow);
  assert_fault_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aux_fault |=> !aux_en);
endmodule

// File: rtl/psc_regs.sv
module psc_regs
  import psc_pkg::*;
#(
  parameter int NUM_HS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_HS-1:0] hs_oc,
  input  logic              aux_oc,
  input  logic              pwm_in,
  input  logic              temp_irq,
  input  logic              volt_irq,
  input  logic              cpu_irq,
  output logic [NUM_HS-1:0] hs_en,
  output logic              aux_en,
  output logic              hb_hi_allow,
  output logic              hb_lo_allow,
  output logic              xmit_allow,
  output logic              stop_req,
  output logic              sleep_req,
  output logic [1:0]        sel_bits
);
  localparam int NF      = NUM_HS + 1;
  localparam int PWM_LSB = 4;

  logic wr_ctrl, wr_drv, wr_stat;
  logic [DW-1:0] ctrl_q, ctrl_nxt;
  logic [NUM_HS-1:0] on_q, pwm_q, on_nxt, pwm_nxt;
  logic [NF-1:0] flt_in, flt_clr, flt_q, flt_nxt;

  assign wr_ctrl = bus_wr && (bus_addr == AW'(CTRL_ADDR));
  assign wr_drv  = bus_wr && (bus_addr == AW'(DRV_ADDR));
  assign wr_stat = bus_wr && (bus_addr == AW'(STAT_ADDR));

  psc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wdata    (bus_wdata),
    .cpu_irq  (cpu_irq),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt),
    .stop_req (stop_req),
    .sleep_req(sleep_req)
  );

  assign on_nxt  = wr_drv ? bus_wdata[NUM_HS-1:0] : on_q;
  assign pwm_nxt = wr_drv ? bus_wdata[PWM_LSB +: NUM_HS] : pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      pwm_q <= '0;
    end else begin
      on_q  <= on_nxt;
      pwm_q <= pwm_nxt;
    end
  end

  assign flt_in  = {aux_oc, hs_oc};
  assign flt_clr = wr_stat ? {bus_wdata[DW-1], bus_wdata[NUM_HS-1:0]} : '0;

  psc_fault_flags #(.NF(NF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (flt_in),
    .clr     (flt_clr),
    .flag_q  (flt_q),
    .flag_nxt(flt_nxt)
  );

  psc_out_stage #(.NUM_HS(NUM_HS)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pson       (ctrl_nxt[PSON_BIT]),
    .hs_tdis    (ctrl_nxt[HSTD_BIT]),
    .ls_tdis    (ctrl_nxt[LSTD_BIT]),
    .v_tdis     (ctrl_nxt[VSD_BIT]),
    .temp_irq   (temp_irq),
    .volt_irq   (volt_irq),
    .hs_on      (on_nxt),
    .hs_pwm_sel (pwm_nxt),
    .pwm_in     (pwm_in),
    .hs_fault   (flt_nxt[NUM_HS-1:0]),
    .aux_fault  (flt_nxt[NUM_HS]),
    .hs_en      (hs_en),
    .aux_en     (aux_en),
    .hb_hi_allow(hb_hi_allow),
    .hb_lo_allow(hb_lo_allow),
    .xmit_allow (xmit_allow)
  );

  assign sel_bits = ctrl_q[1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(CTRL_ADDR)) begin
      bus_rdata = ctrl_q;
    end else if (bus_addr == AW'(DRV_ADDR)) begin
      bus_rdata[NUM_HS-1:0]        = on_q;
      bus_rdata[PWM_LSB +: NUM_HS] = pwm_q;
    end else if (bus_addr == AW'(STAT_ADDR)) begin
      bus_rdata[NUM_HS-1:0] = flt_q[NUM_HS-1:0];
      bus_rdata[DW-1]       = flt_q[NUM_HS];
    end
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && hs_oc[0]) |=> flt_q[0]);
  assert_stat_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(STAT_ADDR)) |-> (bus_rdata[6:3] == 4'b0));
  assert_ctrl_wo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(CTRL_ADDR)) |-> (bus_rdata[6:5] == 2'b0));
endmodule

// File: tb/psc_regs_bench.sv
module psc_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] hs_oc = '0;
  logic       aux_oc = 1'b0, pwm_in = 1'b0, temp_irq = 1'b0, volt_irq = 1'b0, cpu_irq = 1'b0;
  logic [2:0] hs_en;
  logic       aux_en, hb_hi_allow, hb_lo_allow, xmit_allow, stop_req, sleep_req;
  logic [1:0] sel_bits;

  always #4 clk = ~clk;

  psc_regs u_psc_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs_oc(hs_oc), .aux_oc(aux_oc),
    .pwm_in(pwm_in), .temp_irq(temp_irq), .volt_irq(volt_irq), .cpu_irq(cpu_irq),
    .hs_en(hs_en), .aux_en(aux_en), .hb_hi_allow(hb_hi_allow), .hb_lo_allow(hb_lo_allow),
    .xmit_allow(xmit_allow), .stop_req(stop_req), .sleep_req(sleep_req), .sel_bits(sel_bits)
  );

  // outs packing: {stop, sleep, xmit, hb_lo, hb_hi, aux, hs_en[2:0]}
  typedef struct {
    string      req;
    bit         is_read;
    logic [8:0] exp;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic logic [8:0] outs();
    return {stop_req, sleep_req, xmit_allow, hb_lo_allow, hb_hi_allow, aux_en, hs_en};
  endfunction

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [8:0] act;
      it  = q.pop_front();
      act = it.is_read ? {1'b0, bus_rdata} : outs();
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual=%h expected=%h", it.req,
                 it.is_read ? "rdata" : "outs", act, it.exp);
      end
    end
  end

  task automatic op(input logic w, input logic [7:0] a, input logic [7:0] d);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
  endtask

  task automatic want(input string req, input bit rd, input logic [8:0] e);
    item_t it;
    it.req = req; it.is_read = rd; it.exp = e;
    q.push_back(it);
  endtask

  task automatic fin();
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wr_out(input logic [7:0] a, input logic [7:0] d, input string req, input logic [8:0] e);
    op(1'b1, a, d); want(req, 1'b0, e); fin();
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [7:0] e);
    op(1'b0, a, 8'h00); want(req, 1'b1, {1'b0, e}); fin();
  endtask

  task automatic idle_out(input string req, input logic [8:0] e);
    op(1'b0, 8'h10, 8'h00); want(req, 1'b0, e); fin();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    idle_out("R1", 9'h000);
    rd(8'h00, "R1", 8'h00);
    rd(8'h02, "R1", 8'h00);
    rd(8'h04, "R1", 8'h00);
    // R2 / R7 power-on and layout
    wr_out(8'h00, 8'h80, "R7", 9'h078);
    wr_out(8'h02, 8'h07, "R7", 9'h07F);
    rd(8'h00, "R2", 8'h80);
    rd(8'h02, "R3", 8'h07);
    // R4 fault on HS2
    hs_oc = 3'b010;
    idle_out("R4", 9'h07D);
    hs_oc = 3'b000;
    idle_out("R4", 9'h07D);
    rd(8'h04, "R4", 8'h02);
    // R5 write 0 no effect, write 1 clears
    wr_out(8'h04, 8'h00, "R5", 9'h07D);
    rd(8'h04, "R5", 8'h02);
    wr_out(8'h04, 8'h02, "R5", 9'h07F);
    rd(8'h04, "R5", 8'h00);
    // R6 set wins over clear
    hs_oc = 3'b001;
    wr_out(8'h04, 8'h01, "R6", 9'h07E);
    hs_oc = 3'b000;
    rd(8'h04, "R6", 8'h01);
    wr_out(8'h04, 8'h01, "R6", 9'h07F);
    // R4 auxiliary fault
    aux_oc = 1'b1;
    idle_out("R4", 9'h077);
    aux_oc = 1'b0;
    rd(8'h04, "R4", 8'h80);
    wr_out(8'h04, 8'h80, "R5", 9'h07F);
    // R8 PWM select
    pwm_in = 1'b1;
    wr_out(8'h02, 8'h50, "R8", 9'h07D);
    rd(8'h02, "R3", 8'h50);
    pwm_in = 1'b0;
    idle_out("R8", 9'h078);
    wr_out(8'h02, 8'h07, "R8", 9'h07F);
    // R9 / R10 thermal
    temp_irq = 1'b1;
    idle_out("R9", 9'h048);
    wr_out(8'h00, 8'h88, "R9", 9'h05F);
    wr_out(8'h00, 8'h90, "R10", 9'h068);
    wr_out(8'h00, 8'h98, "R10", 9'h07F);
    temp_irq = 1'b0;
    // R11 voltage
    wr_out(8'h00, 8'h80, "R11", 9'h07F);
    volt_irq = 1'b1;
    idle_out("R11", 9'h000);
    wr_out(8'h00, 8'h84, "R11", 9'h07F);
    volt_irq = 1'b0;
    // R7 power-off gates all
    wr_out(8'h00, 8'h00, "R7", 9'h000);
    // R12 mode commands
    wr_out(8'h00, 8'h40, "R12", 9'h100);
    idle_out("R12", 9'h000);
    rd(8'h00, "R2", 8'h00);
    wr_out(8'h00, 8'h23, "R12", 9'h080);
    idle_out("R12", 9'h000);
    rd(8'h00, "R12", 8'h03);
    wr_out(8'h00, 8'h44, "R12", 9'h000);
    rd(8'h00, "R12", 8'h04);
    wr_out(8'h00, 8'h60, "R12", 9'h000);
    // R13 CPU interrupt cancels
    cpu_irq = 1'b1;
    wr_out(8'h00, 8'h40, "R13", 9'h000);
    wr_out(8'h00, 8'h20, "R13", 9'h000);
    cpu_irq = 1'b0;
    wr_out(8'h00, 8'h40, "R13", 9'h100);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule